// File: doc/BRIEF.md
# MAC accumulator readout formatter

This block turns a wide multiply-accumulate accumulator value into a register-width result, following the mode bits of the MAC unit that are currently in force. It offers three readout formats. Fractional readout shifts the binary point and can round to even. Signed integer readout saturates to the 32-bit signed range. Unsigned readout clamps to all ones.

For fractional readout the rounding granularity depends on the mode. With the sixteen-bit mode bit set, the result is the 16-bit field above a 24-bit remainder, and it is always rounded. Otherwise the result is the 32-bit field above an 8-bit remainder, and it is rounded only when the rounding bit is set. Both roundings resolve an exact half toward an even result. Saturation of a fractional result happens only when the overflow-mode bit is set. Without that bit the rounded value is simply truncated.

The datapath is combinational. A parameter adds one output register stage, which is present by default. The accumulator storage and the multiplier sit outside this block.

Top module: `mac_readout_fmt`

## Requirements
- R1: With OUT_REG=1 the result appears on `result` one clock after the inputs are presented. An active-low asynchronous `rst_n` forces `result` to zero.
- R2: With `fmt`=0 (fractional) and `su`=1, the accumulator is shifted right arithmetically by 24. One is added when bits [23:0] exceed 0x800000. When they equal 0x800000 exactly, the least significant bit of the shifted value is added. The upper 16 bits of `result` are zero, and `rt` has no effect.
- R3: With `fmt`=0, `su`=0 and `rt`=1, the accumulator is shifted right arithmetically by 8. One is added when bits [7:0] exceed 0x80. When they equal 0x80 exactly, the least significant bit of the shifted value is added.
- R4: With `fmt`=0, `su`=0 and `rt`=0, the result is the accumulator shifted right arithmetically by 8, with no rounding.
- R5: With `fmt`=0, `su`=1 and `omc`=1, a rounded value outside the signed 16-bit range gives 0x7FFF when it is positive and 0x8000 when it is negative. A value inside that range gives its low 16 bits.
- R6: With `fmt`=0, `su`=0 and `omc`=1, a rounded value outside the signed 32-bit range gives 0x7FFFFFFF when it is positive and 0x80000000 when it is negative.
- R7: With `fmt`=0 and `omc`=0, the result is the low 16 bits (`su`=1) or the low 32 bits (`su`=0) of the rounded value, even when that value is out of range.
- R8: With `fmt`=1 (signed integer), an accumulator that fits in signed 32 bits is passed through as its low 32 bits. Otherwise the result is 0x7FFFFFFF if the accumulator is positive and 0x80000000 if it is negative. The mode bits are ignored.
- R9: With `fmt`=2 (unsigned), the result is the low 32 bits when bits [63:32] are all zero, and 0xFFFFFFFF otherwise.
- R10: `fmt`=3 is reserved and yields a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | 64 | Accumulator value, two's complement |
| su | input | 1 | Sixteen-bit fractional mode |
| rt | input | 1 | Round enable for the 32-bit fractional mode |
| omc | input | 1 | Saturate on overflow |
| fmt | input | 2 | Readout format: 0 fractional, 1 signed, 2 unsigned, 3 reserved |
| result | output | 32 | Formatted result |

## Verification
The bench drives exact half-way remainders with both an even and an odd least significant bit, at both rounding granularities. A design that rounded half up, or that ignored the least significant bit, would return an odd value where an even one is expected. It also drives cases where rounding carries the value just past the positive limit. A design that checked the range before rounding would then return 0x8000 or 0x80000000 instead of the clamp value. Negative overflows in the fractional and signed paths expose a saturation value picked by the wrong sign. Out-of-range inputs with `omc` clear catch a design that saturates when it should truncate.

// File: rtl/mac_readout_pkg.sv
package mac_readout_pkg;
    typedef enum logic [1:0] {
        FMT_FRAC = 2'd0,
        FMT_SINT = 2'd1,
        FMT_UINT = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;
endpackage

// File: rtl/mac_round_shift.sv
// Arithmetic right shift by SHIFT with optional round-half-to-even.
module mac_round_shift #(
    parameter int W     = 64,
    parameter int SHIFT = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         rnd_en_i,
    output logic [W-1:0] val_o
);
    localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};

    logic [W-1:0]     shifted;
    logic [SHIFT-1:0] rem;
    logic             bump;

    always_comb begin
        shifted = W'($signed(val_i) >>> SHIFT);
        rem     = val_i[SHIFT-1:0];
        bump    = rnd_en_i && ((rem > HALF) || ((rem == HALF) && shifted[0]));
        val_o   = shifted + {{(W-1){1'b0}}, bump};
    end
endmodule

// File: rtl/mac_sat_clamp.sv
// Narrows a signed value to OUT_W bits; saturates by sign when enabled.
module mac_sat_clamp #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    input  logic             sat_en_i,
    output logic [OUT_W-1:0] val_o
);
    localparam int TOP_W = IN_W - OUT_W + 1;
    localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

    logic [TOP_W-1:0] top;
    logic             fits;

    always_comb begin
        top  = val_i[IN_W-1:OUT_W-1];
        fits = (top == '0) || (top == '1);
        if (sat_en_i && !fits) begin
            val_o = val_i[IN_W-1] ? NEG_LIM : POS_LIM;
        end else begin
            val_o = val_i[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/mac_readout_fmt.sv
module mac_readout_fmt
    import mac_readout_pkg::*;
#(
    parameter int ACC_W    = 64,
    parameter int RES_W    = 32,
    parameter int SU_SHIFT = 24,
    parameter int RT_SHIFT = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             su,
    input  logic             rt,
    input  logic             omc,
    input  logic [1:0]       fmt,
    output logic [RES_W-1:0] result
);
    localparam int HALF_W = RES_W / 2;

    typedef struct packed {
        logic [RES_W-1:0] result;
    } state_t;

    state_t           st_d, st_q;
    logic [ACC_W-1:0] su_rounded, rt_rounded;
    logic [HALF_W-1:0] half_res;
    logic [RES_W-1:0] word_res, sint_res, uint_res;

    mac_round_shift #(.W(ACC_W), .SHIFT(SU_SHIFT)) u_su_round (
        .val_i(acc_in), .rnd_en_i(1'b1), .val_o(su_rounded)
    );

    mac_round_shift #(.W(ACC_W), .SHIFT(RT_SHIFT)) u_rt_round (
        .val_i(acc_in), .rnd_en_i(rt), .val_o(rt_rounded)
    );

    mac_sat_clamp #(.IN_W(ACC_W), .OUT_W(HALF_W)) u_half_sat (
        .val_i(su_rounded), .sat_en_i(omc), .val_o(half_res)
    );

    mac_sat_clamp #(.IN_W(ACC_W), .OUT_W(RES_W)) u_word_sat (
        .val_i(rt_rounded), .sat_en_i(omc), .val_o(word_res)
    );

    mac_sat_clamp #(.IN_W(ACC_W), .OUT_W(RES_W)) u_sint_sat (
        .val_i(acc_in), .sat_en_i(1'b1), .val_o(sint_res)
    );

    assign uint_res = (acc_in[ACC_W-1:RES_W] == '0) ? acc_in[RES_W-1:0] : '1;

    always_comb begin
        st_d = '0;
        case (fmt_e'(fmt))
            FMT_FRAC: begin
                if (su) begin
                    st_d.result = {{(RES_W-HALF_W){1'b0}}, half_res};
                end else begin
                    st_d.result = word_res;
                end
            end
            FMT_SINT: st_d.result = sint_res;
            FMT_UINT: st_d.result = uint_res;
            default:  st_d.result = '0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
            assign result = st_q.result;
        end else begin : g_comb
            assign st_q   = st_d;
            assign result = st_d.result;
        end
    endgenerate
endmodule

// File: rtl/mac_readout_fmt_chk.sv
module mac_readout_fmt_chk
    import mac_readout_pkg::*;
#(
    parameter int ACC_W    = 64,
    parameter int RES_W    = 32,
    parameter int RT_SHIFT = 8,
    parameter bit OUT_REG  = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] acc_in,
    input logic             su,
    input logic             rt,
    input logic             omc,
    input logic [1:0]       fmt,
    input logic [RES_W-1:0] result
);
    localparam int HALF_W = RES_W / 2;

    generate
        if (OUT_REG) begin : g_chk
            // R1
            reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> result == '0);

            // R9
            uint_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_UINT && acc_in[ACC_W-1:RES_W] != '0) |=> result == '1);

            // R9
            uint_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_UINT && acc_in[ACC_W-1:RES_W] == '0)
                |=> result == $past(acc_in[RES_W-1:0]));

            // R8
            sint_pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_SINT && !acc_in[ACC_W-1] && acc_in[ACC_W-2:RES_W-1] != '0)
                |=> result == {1'b0, {(RES_W-1){1'b1}}});

            // R2
            su_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_FRAC && su) |=> result[RES_W-1:HALF_W] == '0);

            // R4
            plain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_FRAC && !su && !rt && !omc)
                |=> result == $past(acc_in[RES_W+RT_SHIFT-1:RT_SHIFT]));

            // R10
            rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fmt == FMT_RSVD) |=> result == '0);
        end
    endgenerate
endmodule

bind mac_readout_fmt mac_readout_fmt_chk #(
    .ACC_W(ACC_W), .RES_W(RES_W), .RT_SHIFT(RT_SHIFT), .OUT_REG(OUT_REG)
) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .su(su), .rt(rt),
    .omc(omc), .fmt(fmt), .result(result)
);

// File: tb/mac_readout_fmt_tb_top.sv
module mac_readout_fmt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 28;

    typedef struct packed {
        logic [63:0] acc;
        logic [2:0]  mode;   // {su, rt, omc}
        logic [1:0]  fmt;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R2 half, even lsb / odd lsb / above / below, and rt ignored
        '{64'h0000_0012_3480_0000, 3'b100, 2'd0, 32'h0000_1234, 8'd2},
        '{64'h0000_0012_3580_0000, 3'b100, 2'd0, 32'h0000_1236, 8'd2},
        '{64'h0000_0012_3480_0001, 3'b100, 2'd0, 32'h0000_1235, 8'd2},
        '{64'h0000_0012_347F_FFFF, 3'b100, 2'd0, 32'h0000_1234, 8'd2},
        '{64'h0000_0012_3580_0000, 3'b110, 2'd0, 32'h0000_1236, 8'd2},
        // R3 half even / half odd / above / below
        '{64'h0000_0000_1234_5680, 3'b010, 2'd0, 32'h0012_3456, 8'd3},
        '{64'h0000_0000_1234_5780, 3'b010, 2'd0, 32'h0012_3458, 8'd3},
        '{64'h0000_0000_1234_5681, 3'b010, 2'd0, 32'h0012_3457, 8'd3},
        '{64'h0000_0000_1234_567F, 3'b010, 2'd0, 32'h0012_3456, 8'd3},
        // R4 truncating shift, positive and negative
        '{64'h0000_0000_1234_56FF, 3'b000, 2'd0, 32'h0012_3456, 8'd4},
        '{64'hFFFF_FFFF_FFFF_FF00, 3'b000, 2'd0, 32'hFFFF_FFFF, 8'd4},
        // R5 16-bit saturation
        '{64'h0000_0100_0000_0000, 3'b101, 2'd0, 32'h0000_7FFF, 8'd5},
        '{64'hFFFF_FF00_0000_0000, 3'b101, 2'd0, 32'h0000_8000, 8'd5},
        '{64'hFFFF_FFFF_FF00_0000, 3'b101, 2'd0, 32'h0000_FFFF, 8'd5},
        '{64'h0000_007F_FFFF_FFFF, 3'b101, 2'd0, 32'h0000_7FFF, 8'd5},
        // R6 32-bit saturation, incl. rounding carry past the limit
        '{64'h0000_0080_0000_0000, 3'b001, 2'd0, 32'h7FFF_FFFF, 8'd6},
        '{64'hFFFF_FF00_0000_0000, 3'b001, 2'd0, 32'h8000_0000, 8'd6},
        '{64'h0000_007F_FFFF_FFC0, 3'b011, 2'd0, 32'h7FFF_FFFF, 8'd6},
        // R7 truncation without omc
        '{64'h0000_007F_FFFF_FFFF, 3'b100, 2'd0, 32'h0000_8000, 8'd7},
        '{64'h0000_0080_0000_0000, 3'b000, 2'd0, 32'h8000_0000, 8'd7},
        // R8 signed integer
        '{64'h0000_0000_1234_5678, 3'b000, 2'd1, 32'h1234_5678, 8'd8},
        '{64'hFFFF_FFFF_8000_0000, 3'b111, 2'd1, 32'h8000_0000, 8'd8},
        '{64'h0000_0000_8000_0000, 3'b000, 2'd1, 32'h7FFF_FFFF, 8'd8},
        '{64'hFFFF_FFFF_7FFF_FFFF, 3'b000, 2'd1, 32'h8000_0000, 8'd8},
        // R9 unsigned
        '{64'h0000_0000_FFFF_FFFE, 3'b000, 2'd2, 32'hFFFF_FFFE, 8'd9},
        '{64'h0000_0001_0000_0000, 3'b000, 2'd2, 32'hFFFF_FFFF, 8'd9},
        '{64'h8000_0000_0000_0005, 3'b111, 2'd2, 32'hFFFF_FFFF, 8'd9},
        // R10 reserved format
        '{64'h0000_0000_0000_1234, 3'b000, 2'd3, 32'h0000_0000, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] acc_in = '0;
    logic        su = 1'b0, rt = 1'b0, omc = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_readout_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .su(su), .rt(rt),
        .omc(omc), .fmt(fmt), .result(result)
    );

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (result !== exp) begin
            fails++;
            $display("FAIL %s: result=%h expected=%h", req, result, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state with live inputs
        acc_in = 64'h0000_0000_1234_5678;
        fmt    = 2'd1;
        repeat (3) @(negedge clk);
        check("R1", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'h1234_5678);

        // table walk: drive on a falling edge, sample one cycle later
        for (int i = 0; i < NVEC; i++) begin
            acc_in = VECS[i].acc;
            {su, rt, omc} = VECS[i].mode;
            fmt = VECS[i].fmt;
            @(negedge clk);
            check($sformatf("R%0d", VECS[i].req), VECS[i].exp);
        end

        // R1 latency: new input not visible before the next rising edge
        acc_in = 64'h0000_0000_0000_00AA;
        {su, rt, omc} = 3'b000;
        fmt = 2'd2;
        @(negedge clk);
        check("R1", 32'h0000_00AA);
        acc_in = 64'h0000_0000_0000_00BB;
        #1;
        check("R1", 32'h0000_00AA);
        @(negedge clk);
        check("R1", 32'h0000_00BB);

        // R1 asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1;
        check("R1", 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'h0000_00BB);

        // R7 negative fractional value without omc keeps only low 16 bits
        acc_in = 64'hFFFF_FFFF_FF00_0000;
        {su, rt, omc} = 3'b100;
        fmt = 2'd0;
        @(negedge clk);
        check("R7", 32'h0000_FFFF);

        // R3 negative half with odd lsb rounds toward even
        acc_in = 64'hFFFF_FFFF_FFFF_FF80;
        {su, rt, omc} = 3'b011;
        @(negedge clk);
        check("R3", 32'h0000_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule